// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. The overall division ratio is the product of a small odd-or-two prescale factor and a power-of-two scale factor, and a double-rate mode halves that ratio. The transfer engine drives a run signal: while it is low the serial clock rests at its idle polarity, and while it is high the clock toggles at the configured rate.

In double-rate mode an odd prescale factor cannot be split into two equal halves. The period is then split into a short and a long phase. The clock-phase setting decides whether the short phase is the active-level phase or the rest-level phase. Every transition of the serial clock comes with a one-cycle strobe, leading or trailing, which a shifter uses to launch and sample data. The configuration is captured when a run starts and is held for the whole run.

Top module: `spi_sck_gen`

## Requirements
- R1: Prescale code 0, 1, 2 and 3 selects factor f = 2, 3, 5 and 7. The scale code s selects a scaler of 2^(s+1). With double rate off, each half period is f·2^s system cycles, so the period is f·2^(s+1).
- R2: With double rate on (and master set), the full period is f·2^s system cycles, which is half the normal period.
- R3: With double rate off, the active phase (leading to trailing edge) and the rest phase (trailing to leading edge) are equal for every prescale, phase and polarity setting.
- R4: With double rate on and prescale code 0, both phases are 2^s cycles long.
- R5: With double rate on and an odd factor, the two phases are ((f-1)/2)·2^s and ((f+1)/2)·2^s cycles. With cpha 0 the active phase is the short one. With cpha 1 it is the long one.
- R6: When is_master is 0, the double-rate input has no effect and the timing is that of R1 and R3.
- R7: Once en is sampled low, sck equals cpol from the next cycle on, and neither strobe is asserted.
- R8: After the edge that samples en high, the first leading edge (sck leaving the cpol level) occurs exactly one rest-phase length later, in system cycles.
- R9: lead_stb is high for exactly one cycle, in the same cycle that sck goes to the opposite of cpol. trail_stb is high for exactly one cycle, in the cycle that sck returns to cpol. The two strobes are never high together, and leading and trailing strobes alternate.
- R10: Changes on pre_code, scale_code, dbr, cpha, cpol and is_master while en stays high do not alter the timing or levels of the current run.
- R11: During reset, sck, lead_stb and trail_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request from the transfer engine |
| is_master | input | 1 | Master operation; gates double rate |
| pre_code | input | 2 | Prescale factor select |
| scale_code | input | SC_W | Power-of-two scaler select |
| dbr | input | 1 | Double-rate mode |
| cpha | input | 1 | Clock phase; picks which phase is short |
| cpol | input | 1 | Idle level of sck |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse at each leading edge |
| trail_stb | output | 1 | One-cycle pulse at each trailing edge |

## Verification
sck and both strobes are registered. An edge that samples en high shows its first leading strobe after rest-length plus one sampling point. Each later edge is due a full phase length, in cycles, after the strobe before it. An edge that samples en low shows the rest level at the very next sampling point. The bench drives on falling clock edges and counts falling edges between strobes. It compares those counts with phase lengths it computes from the prescale factor and scaler, and it checks every run's measurements against the configuration that was held when the run began.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;

  typedef struct packed {
    logic [1:0] pre;
    logic       dbr;
    logic       cpha;
    logic       cpol;
  } sck_mode_t;

  // Prescale factor per code; ordering is behavioural.
  function automatic logic [2:0] pre_factor(input logic [1:0] code);
    case (code)
      2'd0:    pre_factor = 3'd2;
      2'd1:    pre_factor = 3'd3;
      2'd2:    pre_factor = 3'd5;
      default: pre_factor = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold
  import sck_div_pkg::*;
#(
  parameter int SC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  sck_mode_t       live_mode,
  input  logic [SC_W-1:0] live_scale,
  output sck_mode_t       eff_mode,
  output logic [SC_W-1:0] eff_scale
);

  sck_mode_t       held_mode_q;
  logic [SC_W-1:0] held_scale_q;
  logic            load_en;

  assign load_en = ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_mode_q  <= '0;
      held_scale_q <= '0;
    end else if (load_en) begin
      held_mode_q  <= live_mode;
      held_scale_q <= live_scale;
    end
  end

  always_comb begin
    eff_mode  = run ? held_mode_q  : live_mode;
    eff_scale = run ? held_scale_q : live_scale;
  end

endmodule

// File: rtl/sck_half_calc.sv
module sck_half_calc
  import sck_div_pkg::*;
#(
  parameter int SC_W  = 4,
  parameter int CNT_W = 2 + (1 << SC_W)
) (
  input  sck_mode_t        mode,
  input  logic [SC_W-1:0]  scale,
  output logic [CNT_W-1:0] act_m1,
  output logic [CNT_W-1:0] rest_m1
);

  logic [2:0]       fac;
  logic [CNT_W-1:0] full_len;
  logic [CNT_W-1:0] unit_len;
  logic [CNT_W-1:0] short_len;
  logic [CNT_W-1:0] long_len;
  logic [CNT_W-1:0] act_len;
  logic [CNT_W-1:0] rest_len;

  always_comb begin
    fac       = pre_factor(mode.pre);
    full_len  = CNT_W'(fac) << scale;
    unit_len  = CNT_W'(1) << scale;
    short_len = CNT_W'(fac >> 1) << scale;
    long_len  = CNT_W'((fac >> 1) + 3'd1) << scale;
    if (!mode.dbr) begin
      act_len  = full_len;
      rest_len = full_len;
    end else if (mode.pre == 2'd0) begin
      act_len  = unit_len;
      rest_len = unit_len;
    end else if (mode.cpha) begin
      act_len  = long_len;
      rest_len = short_len;
    end else begin
      act_len  = short_len;
      rest_len = long_len;
    end
    act_m1  = act_len - CNT_W'(1);
    rest_m1 = rest_len - CNT_W'(1);
  end

endmodule

// File: rtl/sck_phase_timer.sv
module sck_phase_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpol_live,
  input  logic [CNT_W-1:0] act_m1,
  input  logic [CNT_W-1:0] rest_m1,
  output logic             run,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb
);

  logic             run_q,   run_n;
  logic             act_q,   act_n;
  logic [CNT_W-1:0] cnt_q,   cnt_n;
  logic             sck_q,   sck_n;
  logic             lead_q,  lead_n;
  logic             trail_q, trail_n;

  always_comb begin
    run_n   = run_q;
    act_n   = act_q;
    cnt_n   = cnt_q;
    sck_n   = sck_q;
    lead_n  = 1'b0;
    trail_n = 1'b0;
    if (!en) begin
      run_n = 1'b0;
      act_n = 1'b0;
      cnt_n = '0;
      sck_n = cpol_live;
    end else if (!run_q) begin
      run_n = 1'b1;
      act_n = 1'b0;
      cnt_n = rest_m1;
      sck_n = cpol_live;
    end else if (cnt_q == '0) begin
      act_n   = ~act_q;
      sck_n   = ~sck_q;
      cnt_n   = act_q ? rest_m1 : act_m1;
      lead_n  = ~act_q;
      trail_n = act_q;
    end else begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      run_q   <= run_n;
      act_q   <= act_n;
      cnt_q   <= cnt_n;
      sck_q   <= sck_n;
      lead_q  <= lead_n;
      trail_q <= trail_n;
    end
  end

  assign run       = run_q;
  assign sck       = sck_q;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import sck_div_pkg::*;
#(
  parameter int SC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            is_master,
  input  logic [1:0]      pre_code,
  input  logic [SC_W-1:0] scale_code,
  input  logic            dbr,
  input  logic            cpha,
  input  logic            cpol,
  output logic            sck,
  output logic            lead_stb,
  output logic            trail_stb
);

  localparam int CNT_W = 2 + (1 << SC_W);

  sck_mode_t        live_mode;
  sck_mode_t        eff_mode;
  logic [SC_W-1:0]  eff_scale;
  logic [CNT_W-1:0] act_m1;
  logic [CNT_W-1:0] rest_m1;
  logic             run;

  always_comb begin
    live_mode.pre  = pre_code;
    live_mode.dbr  = dbr & is_master;
    live_mode.cpha = cpha;
    live_mode.cpol = cpol;
  end

  sck_cfg_hold #(.SC_W(SC_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .live_mode  (live_mode),
    .live_scale (scale_code),
    .eff_mode   (eff_mode),
    .eff_scale  (eff_scale)
  );

  sck_half_calc #(.SC_W(SC_W), .CNT_W(CNT_W)) u_calc (
    .mode    (eff_mode),
    .scale   (eff_scale),
    .act_m1  (act_m1),
    .rest_m1 (rest_m1)
  );

  sck_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cpol_live (cpol),
    .act_m1    (act_m1),
    .rest_m1   (rest_m1),
    .run       (run),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

endmodule

// File: rtl/sck_gen_chk.sv
module sck_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic sck,
  input logic lead_stb,
  input logic trail_stb
);

  logic last_was_lead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_was_lead_q <= 1'b0;
    else if (!en)       last_was_lead_q <= 1'b0;
    else if (lead_stb)  last_was_lead_q <= 1'b1;
    else if (trail_stb) last_was_lead_q <= 1'b0;
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R9
  lead_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  // R9
  trail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |=> !trail_stb);

  // R9
  lead_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sck != $past(sck)));

  // R9
  trail_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sck != $past(sck)));

  // R9
  strobe_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last_was_lead_q) |-> !lead_stb);

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sck == $past(cpol)) && !lead_stb && !trail_stb);

endmodule

bind spi_sck_gen sck_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .cpol      (cpol),
  .sck       (sck),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb)
);

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;

  localparam int SC_W = 2;

  logic            clk;
  logic            rst_n;
  logic            en;
  logic            is_master;
  logic [1:0]      pre_code;
  logic [SC_W-1:0] scale_code;
  logic            dbr;
  logic            cpha;
  logic            cpol;
  logic            sck;
  logic            lead_stb;
  logic            trail_stb;

  int checks;
  int failures;
  int cyc;
  bit done;

  spi_sck_gen #(.SC_W(SC_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .is_master  (is_master),
    .pre_code   (pre_code),
    .scale_code (scale_code),
    .dbr        (dbr),
    .cpha       (cpha),
    .cpol       (cpol),
    .sck        (sck),
    .lead_stb   (lead_stb),
    .trail_stb  (trail_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 200000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Counts falling edges until the wanted strobe; flags any other strobe.
  task automatic wait_evt(input bit want_lead, output int n, output bit bad);
    n = 0;
    bad = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      n++;
      if (want_lead ? lead_stb : trail_stb) break;
      if (lead_stb || trail_stb) bad = 1'b1;
    end
  endtask

  function automatic int fac_of(input int p);
    case (p)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  initial begin
    int n1, n2, n3;
    bit b1, b2, b3;
    checks = 0;
    failures = 0;
    cyc = 0;
    done = 1'b0;
    rst_n = 1'b0;
    en = 1'b0;
    is_master = 1'b1;
    pre_code = '0;
    scale_code = '0;
    dbr = 1'b0;
    cpha = 1'b0;
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 sck", int'(sck), 0);
    chk("R11 lead", int'(lead_stb), 0);
    chk("R11 trail", int'(trail_stb), 0);
    rst_n = 1'b1;

    for (int m = 0; m < 2; m++)
    for (int d = 0; d < 2; d++)
    for (int p = 0; p < 4; p++)
    for (int s = 0; s < (1 << SC_W); s++)
    for (int ph = 0; ph < 2; ph++)
    for (int pol = 0; pol < 2; pol++) begin
      int f, unit, a_len, b_len;
      bit de;
      string tag;
      f = fac_of(p);
      unit = 1 << s;
      de = (d == 1) && (m == 1);
      if (!de) begin
        a_len = f * unit; b_len = f * unit;
        tag = (d == 1) ? "R6" : "R1";
      end else if (p == 0) begin
        a_len = unit; b_len = unit; tag = "R4";
      end else if (ph == 0) begin
        a_len = (f - 1) / 2 * unit; b_len = (f + 1) / 2 * unit; tag = "R5";
      end else begin
        a_len = (f + 1) / 2 * unit; b_len = (f - 1) / 2 * unit; tag = "R5";
      end

      @(negedge clk);
      en = 1'b0;
      is_master = m[0];
      dbr = d[0];
      pre_code = 2'(p);
      scale_code = SC_W'(s);
      cpha = ph[0];
      cpol = pol[0];
      @(negedge clk);
      @(negedge clk);
      // R7
      chk("R7 rest level", int'(sck), pol);
      chk("R7 no strobe", int'(lead_stb | trail_stb), 0);

      en = 1'b1;
      wait_evt(1'b1, n1, b1);
      // R8
      chk("R8 first lead delay", n1, b_len + 1);
      chk("R9 lead level", int'(sck), 1 - pol);
      chk("R9 stray strobe", int'(b1), 0);

      // R10: disturb every configuration input mid-run
      pre_code = ~pre_code;
      scale_code = scale_code ^ SC_W'(1);
      dbr = ~dbr;
      cpha = ~cpha;
      cpol = ~cpol;
      is_master = ~is_master;

      wait_evt(1'b0, n1, b1);
      chk({tag, " active phase"}, n1, a_len);
      chk("R9 trail level", int'(sck), pol);
      wait_evt(1'b1, n2, b2);
      chk({tag, " rest phase"}, n2, b_len);
      wait_evt(1'b0, n3, b3);
      chk("R10 active held", n3, a_len);
      chk("R10 level held", int'(sck), pol);
      chk("R9 alternation", int'(b1 | b2 | b3), 0);
      if (de) chk("R2 halved period", n1 + n2, f * unit);
      else    chk("R1 full period", n1 + n2, 2 * f * unit);
      if (!de) chk("R3 equal halves", n1, n2);

      en = 1'b0;
      @(negedge clk);
      chk("R7 stop level", int'(sck), 1 - pol);
      chk("R7 stop strobes", int'(lead_stb | trail_stb), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule